// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line Status Word

This block recovers characters from an asynchronous serial input. The line is sampled on a one-cycle enable that runs at sixteen times the bit rate, so the block needs no clock of its own for the baud rate. A falling edge on the idle line starts a frame. The block checks the start bit at its centre, then reads the data bits, an optional parity bit and one or two stop bits at their centres. Each finished character is handed to the host on a data bus with a one-cycle valid pulse.

Beside the data path the block keeps an 8-bit line status word that the host reads and writes. The four error flags (break, framing, parity, overrun) are sticky and clear when the host reads the word. The receive-ready bit drives the interrupt request. A host write that carries a zero in bit 0 acknowledges the request and frees the one-character holding buffer. The two transmitter bits in the word are registered copies of status inputs from a neighbouring transmitter. The line format comes from the same length, parity and stop fields the transmitter uses.

Top module: `serial_rx_lsr`

## Requirements
- R1: After synchronous reset the status word reads 0x60, `irq` and `rx_valid` are 0 and `rx_data` is 0x00.
- R2: A low level seen on an oversample tick starts a frame only if the line is still low 8 ticks later. If the line is high at that point, the event is dropped and no character, pulse or flag results.
- R3: Data bits arrive least significant first and are sampled every 16 ticks after the start-bit centre. The length field selects 5 (00), 6 (01), 7 (10) or 8 (11) bits. Shorter characters are right-aligned in `rx_data` and the unused upper bits are 0.
- R4: The parity field selects the mode: bit 0 = 0 means no parity bit, 001 means odd, 011 means even, 101 means the parity bit must be 1, and 111 means it must be 0. A mismatch sets status bit 2.
- R5: A low first stop bit sets status bit 3, and the character is still delivered.
- R6: When every sample of a frame is low (start, data, parity if enabled, first stop), status bit 4 is set along with bit 3.
- R7: A character that completes while bit 0 is clear is written to `rx_data`. `rx_valid` pulses for one cycle, bit 0 becomes 1, and `irq` equals bit 0.
- R8: A character that completes while bit 0 is still 1 sets status bit 1. `rx_data` keeps the old character and `rx_valid` does not pulse.
- R9: A one-cycle `lsr_rd` clears bits 4 to 1 from the next cycle and leaves bit 0 alone. An error event in the same cycle still sets its bit.
- R10: A write with `lsr_wdata[0]` = 0 clears bit 0 and `irq`. A write with `lsr_wdata[0]` = 1 changes nothing, and bits 7 to 1 of a write are ignored.
- R11: Status bit 7 is always 0. Bits 6 and 5 follow `tx_idle` and `tx_empty` one cycle later.
- R12: With `two_stop` = 1 the character is delivered at the first stop centre. The second stop bit is sampled 16 ticks later, and if it is low, bit 3 is set and no character is added.
- R13: After a frame ends on a low sample, no new frame starts until the line has been seen high on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Asynchronous serial input, idle high |
| os_tick | input | 1 | One-cycle enable at 16x the bit rate |
| char_len | input | 2 | Character length code (5 to 8 bits) |
| parity_mode | input | 3 | Parity mode code |
| two_stop | input | 1 | 1 = two stop bits expected |
| lsr_rd | input | 1 | Host read strobe for the status word |
| lsr_wr | input | 1 | Host write strobe for the status word |
| lsr_wdata | input | 8 | Host write data; only bit 0 acts |
| tx_idle | input | 1 | Transmitter idle indication |
| tx_empty | input | 1 | Transmit buffer empty indication |
| rx_data | output | 8 | Last accepted character, right-aligned |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is loaded |
| lsr | output | 8 | Line status word |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench drives short glitches that never reach the start-bit centre. A receiver that skipped start validation would deliver phantom characters. It sends 5- and 7-bit characters with ones in the positions above the character length; a receiver that aligned or masked them wrongly would return stray high bits. Each parity mode is driven with both a correct and a wrong parity bit, which exposes swapped odd/even checks and inverted stick-parity checks. A break is held low for many bit times to catch a receiver that re-triggers on a line that never went high, and a second character is sent without an acknowledge to catch a receiver that overwrites the held character or clears the ready bit on a read.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    // Status word bit positions (host decodes these)
    localparam int LSR_RDY = 0;
    localparam int LSR_OVR = 1;
    localparam int LSR_PAR = 2;
    localparam int LSR_FRM = 3;
    localparam int LSR_BRK = 4;
    localparam int LSR_TXE = 5;
    localparam int LSR_TXI = 6;

    typedef struct packed {
        logic [1:0] len;
        logic [2:0] par;
        logic       two_stop;
    } line_cfg_t;

    typedef struct packed {
        logic [7:0] data;
        logic       par_err;
        logic       frm_err;
        logic       brk;
    } rx_char_t;

    typedef enum logic [2:0] {
        S_HUNT,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_STOP2
    } rx_state_e;

    // index of the last data bit: 4 for five bits up to 7 for eight bits
    function automatic logic [2:0] last_bit_idx(input logic [1:0] len);
        return 3'd4 + {1'b0, len};
    endfunction

    function automatic logic parity_on(input logic [2:0] mode);
        return mode[0];
    endfunction

    // data_xor: xor of received data bits, pbit: received parity bit
    function automatic logic parity_bad(input logic [2:0] mode,
                                        input logic       data_xor,
                                        input logic       pbit);
        case (mode)
            3'b001:  return ~(data_xor ^ pbit);
            3'b011:  return data_xor ^ pbit;
            3'b101:  return ~pbit;
            3'b111:  return pbit;
            default: return 1'b0;
        endcase
    endfunction

    // characters shift in at the top; move them down to bit 0
    function automatic logic [7:0] align_char(input logic [7:0] sh,
                                              input logic [1:0] len);
        return sh >> (2'd3 - len);
    endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain_q[0] <= 1'b1;
                else     chain_q[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain_q[g] <= 1'b1;
                else     chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
    import serial_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rxd_s,
    input  logic      os_tick,
    input  line_cfg_t cfg,
    output logic      done,
    output rx_char_t  ch,
    output logic      late_fe
);
    localparam int CW = $clog2(OVERSAMPLE);
    localparam logic [CW-1:0] CNT_LAST = CW'(OVERSAMPLE - 1);
    localparam logic [CW-1:0] CNT_MID  = CW'(OVERSAMPLE / 2 - 1);

    rx_state_e state_q;
    logic [CW-1:0] cnt_q;
    logic [2:0]    idx_q;
    logic [7:0]    sh_q;
    logic          xor_q;
    logic          pbit_q;
    logic          seen_one_q;
    logic          armed_q;
    line_cfg_t     cfg_q;

    logic at_centre;
    assign at_centre = os_tick && (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= S_HUNT;
            cnt_q      <= '0;
            idx_q      <= '0;
            sh_q       <= '0;
            xor_q      <= 1'b0;
            pbit_q     <= 1'b0;
            seen_one_q <= 1'b0;
            armed_q    <= 1'b0;
            cfg_q      <= '0;
            done       <= 1'b0;
            ch         <= '0;
            late_fe    <= 1'b0;
        end else begin
            done    <= 1'b0;
            late_fe <= 1'b0;
            case (state_q)
                S_HUNT: begin
                    if (os_tick) begin
                        if (rxd_s) begin
                            armed_q <= 1'b1;
                        end else if (armed_q) begin
                            state_q <= S_START;
                            cnt_q   <= '0;
                            cfg_q   <= cfg;
                        end
                    end
                end
                S_START: begin
                    if (os_tick) begin
                        if (cnt_q == CNT_MID) begin
                            cnt_q <= '0;
                            if (!rxd_s) begin
                                state_q    <= S_DATA;
                                idx_q      <= '0;
                                sh_q       <= '0;
                                xor_q      <= 1'b0;
                                seen_one_q <= 1'b0;
                            end else begin
                                state_q <= S_HUNT;
                            end
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                end
                S_DATA: begin
                    if (at_centre) begin
                        cnt_q      <= '0;
                        sh_q       <= {rxd_s, sh_q[7:1]};
                        xor_q      <= xor_q ^ rxd_s;
                        seen_one_q <= seen_one_q | rxd_s;
                        if (idx_q == last_bit_idx(cfg_q.len))
                            state_q <= parity_on(cfg_q.par) ? S_PAR : S_STOP;
                        else
                            idx_q <= idx_q + 3'd1;
                    end else if (os_tick) begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                S_PAR: begin
                    if (at_centre) begin
                        cnt_q      <= '0;
                        pbit_q     <= rxd_s;
                        seen_one_q <= seen_one_q | rxd_s;
                        state_q    <= S_STOP;
                    end else if (os_tick) begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                S_STOP: begin
                    if (at_centre) begin
                        cnt_q      <= '0;
                        done       <= 1'b1;
                        ch.data    <= align_char(sh_q, cfg_q.len);
                        ch.par_err <= parity_on(cfg_q.par) &&
                                      parity_bad(cfg_q.par, xor_q, pbit_q);
                        ch.frm_err <= ~rxd_s;
                        ch.brk     <= ~rxd_s & ~seen_one_q;
                        if (rxd_s && cfg_q.two_stop) begin
                            state_q <= S_STOP2;
                        end else begin
                            state_q <= S_HUNT;
                            armed_q <= rxd_s;
                        end
                    end else if (os_tick) begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                S_STOP2: begin
                    if (at_centre) begin
                        cnt_q   <= '0;
                        late_fe <= ~rxd_s;
                        armed_q <= rxd_s;
                        state_q <= S_HUNT;
                    end else if (os_tick) begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                default: state_q <= S_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
    import serial_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       done,
    input  rx_char_t   ch,
    input  logic       late_fe,
    input  logic       lsr_rd,
    input  logic       lsr_wr,
    input  logic       wbit0,
    input  logic       tx_idle,
    input  logic       tx_empty,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic [7:0] lsr,
    output logic       irq
);
    logic rdy_q, ovr_q, par_q, frm_q, brk_q, txi_q, txe_q;
    logic ack, store;

    assign ack   = lsr_wr && !wbit0;
    assign store = done && (!rdy_q || ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
            rdy_q    <= 1'b0;
            ovr_q    <= 1'b0;
            par_q    <= 1'b0;
            frm_q    <= 1'b0;
            brk_q    <= 1'b0;
            txi_q    <= 1'b1;
            txe_q    <= 1'b1;
        end else begin
            rx_valid <= store;
            txi_q    <= tx_idle;
            txe_q    <= tx_empty;
            if (store) begin
                rx_data <= ch.data;
                rdy_q   <= 1'b1;
            end else if (ack) begin
                rdy_q <= 1'b0;
            end
            ovr_q <= (ovr_q && !lsr_rd) || (done && rdy_q && !ack);
            par_q <= (par_q && !lsr_rd) || (done && ch.par_err);
            frm_q <= (frm_q && !lsr_rd) || (done && ch.frm_err) || late_fe;
            brk_q <= (brk_q && !lsr_rd) || (done && ch.brk);
        end
    end

    always_comb begin
        lsr          = '0;
        lsr[LSR_RDY] = rdy_q;
        lsr[LSR_OVR] = ovr_q;
        lsr[LSR_PAR] = par_q;
        lsr[LSR_FRM] = frm_q;
        lsr[LSR_BRK] = brk_q;
        lsr[LSR_TXE] = txe_q;
        lsr[LSR_TXI] = txi_q;
    end

    assign irq = rdy_q;
endmodule

// File: rtl/serial_rx_lsr.sv
module serial_rx_lsr
    import serial_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rxd,
    input  logic       os_tick,
    input  logic [1:0] char_len,
    input  logic [2:0] parity_mode,
    input  logic       two_stop,
    input  logic       lsr_rd,
    input  logic       lsr_wr,
    input  logic [7:0] lsr_wdata,
    input  logic       tx_idle,
    input  logic       tx_empty,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic [7:0] lsr,
    output logic       irq
);
    logic      rxd_s;
    line_cfg_t cfg;
    logic      frame_done;
    rx_char_t  frame_char;
    logic      late_fe;
    logic      unused_wbits;

    assign cfg          = '{len: char_len, par: parity_mode, two_stop: two_stop};
    assign unused_wbits = ^lsr_wdata[7:1];

    serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (rxd_s)
    );

    serial_rx_framer #(.OVERSAMPLE(OVERSAMPLE)) u_framer (
        .clk     (clk),
        .rst     (rst),
        .rxd_s   (rxd_s),
        .os_tick (os_tick),
        .cfg     (cfg),
        .done    (frame_done),
        .ch      (frame_char),
        .late_fe (late_fe)
    );

    serial_rx_status u_status (
        .clk      (clk),
        .rst      (rst),
        .done     (frame_done),
        .ch       (frame_char),
        .late_fe  (late_fe),
        .lsr_rd   (lsr_rd),
        .lsr_wr   (lsr_wr),
        .wbit0    (lsr_wdata[0]),
        .tx_idle  (tx_idle),
        .tx_empty (tx_empty),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .lsr      (lsr),
        .irq      (irq)
    );
endmodule

// File: rtl/serial_rx_lsr_chk.sv
module serial_rx_lsr_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] rx_data,
    input logic       rx_valid,
    input logic [7:0] lsr,
    input logic       irq,
    input logic       lsr_rd,
    input logic       lsr_wr,
    input logic       wbit0,
    input logic [1:0] char_len,
    input logic       frame_done,
    input logic       late_fe
);
    logic ack;
    assign ack = lsr_wr && !wbit0;

    // R7
    a_r7_valid_sets_ready: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (irq && lsr[0]));

    // R7
    a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R10
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack && !frame_done) |=> !irq);

    // R10
    a_r10_request_holds: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack) |=> irq);

    // R9
    a_r9_read_clears_errors: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && !frame_done && !late_fe) |=> (lsr[4:1] == 4'b0000));

    // R8
    a_r8_overrun_keeps_old: assert property (@(posedge clk) disable iff (rst)
        (frame_done && irq && !ack) |=> (lsr[1] && $stable(rx_data) && !rx_valid));

    // R3
    a_r3_short_char_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && char_len == 2'b00) |-> (rx_data[7:5] == 3'b000));

    // R6
    a_r6_break_with_framing: assert property (@(posedge clk) disable iff (rst)
        $rose(lsr[4]) |-> lsr[3]);
endmodule

bind serial_rx_lsr serial_rx_lsr_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .lsr        (lsr),
    .irq        (irq),
    .lsr_rd     (lsr_rd),
    .lsr_wr     (lsr_wr),
    .wbit0      (lsr_wdata[0]),
    .char_len   (char_len),
    .frame_done (frame_done),
    .late_fe    (late_fe)
);

// File: tb/tb_serial_rx_lsr.sv
module tb_serial_rx_lsr;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       os_tick = 1'b0;
    logic [1:0] char_len = 2'b11;
    logic [2:0] parity_mode = 3'b000;
    logic       two_stop = 1'b0;
    logic       lsr_rd = 1'b0;
    logic       lsr_wr = 1'b0;
    logic [7:0] lsr_wdata = 8'h00;
    logic       tx_idle = 1'b1;
    logic       tx_empty = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic [7:0] lsr;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];

    serial_rx_lsr dut (
        .clk(clk), .rst(rst), .rxd(rxd), .os_tick(os_tick),
        .char_len(char_len), .parity_mode(parity_mode), .two_stop(two_stop),
        .lsr_rd(lsr_rd), .lsr_wr(lsr_wr), .lsr_wdata(lsr_wdata),
        .tx_idle(tx_idle), .tx_empty(tx_empty),
        .rx_data(rx_data), .rx_valid(rx_valid), .lsr(lsr), .irq(irq)
    );

    always #2.5 clk = ~clk;

    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            os_tick = 1'b1;
            @(negedge clk);
            os_tick = 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor (R7)
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rx_valid) begin
                if (exp_q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R7: actual=0x%0h expected=no character", rx_data);
                end else begin
                    check("R7 scoreboard data", {24'd0, rx_data}, {24'd0, exp_q.pop_front()});
                end
            end
        end
    end

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic idle_bits(input int n);
        rxd = 1'b1;
        repeat (n * BIT_CLKS) @(negedge clk);
    endtask

    function automatic logic calc_par(input logic [2:0] m, input logic [7:0] d, input int nb);
        logic x = 1'b0;
        for (int i = 0; i < nb; i++) x ^= d[i];
        case (m)
            3'b001:  return ~x;
            3'b011:  return x;
            3'b101:  return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic send_frame(input logic [7:0] d, input logic pbit,
                              input logic s1, input logic s2);
        int nb = 5 + int'(char_len);
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(d[i]);
        if (parity_mode[0]) drive_bit(pbit);
        drive_bit(s1);
        if (two_stop) drive_bit(s2);
        rxd = 1'b1;
    endtask

    // well-formed frame with correct parity, expected into the scoreboard
    task automatic send_good(input logic [7:0] d, input logic [7:0] expect_data);
        exp_q.push_back(expect_data);
        send_frame(d, calc_par(parity_mode, d, 5 + int'(char_len)), 1'b1, 1'b1);
        idle_bits(1);
    endtask

    task automatic host_read(output logic [7:0] v);
        v = lsr;
        lsr_rd = 1'b1;
        @(negedge clk);
        lsr_rd = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] v);
        lsr_wdata = v;
        lsr_wr = 1'b1;
        @(negedge clk);
        lsr_wr = 1'b0;
        lsr_wdata = 8'h00;
    endtask

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 lsr", {24'd0, lsr}, 32'h60);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 rx_data", {24'd0, rx_data}, 32'h00);
        idle_bits(1);

        // R7 plain 8-bit character
        send_good(8'hA5, 8'hA5);
        check("R7 lsr ready", {24'd0, lsr}, 32'h61);
        check("R7 irq", {31'd0, irq}, 32'd1);
        // R10 write of 1 in bit 0 and junk above does nothing
        host_write(8'hFF);
        check("R10 write one ignored", {24'd0, lsr}, 32'h61);
        host_write(8'hFE);
        check("R10 ack clears", {24'd0, lsr}, 32'h60);
        check("R10 irq low", {31'd0, irq}, 32'd0);

        // R3 five-bit and seven-bit characters right-aligned
        char_len = 2'b00;
        send_good(8'hF5, 8'h15);
        check("R3 five-bit data", {24'd0, rx_data}, 32'h15);
        host_write(8'h00);
        char_len = 2'b10;
        send_good(8'hDA, 8'h5A);
        check("R3 seven-bit data", {24'd0, rx_data}, 32'h5A);
        host_write(8'h00);
        char_len = 2'b11;

        // R4 even parity, good then bad
        parity_mode = 3'b011;
        send_good(8'h33, 8'h33);
        check("R4 even good", {24'd0, lsr}, 32'h61);
        host_write(8'h00);
        exp_q.push_back(8'h31);
        send_frame(8'h31, 1'b0, 1'b1, 1'b1); idle_bits(1);
        check("R4 even bad", {24'd0, lsr}, 32'h65);
        // R9 read returns flags then clears them, ready stays
        host_read(v);
        check("R9 read value", {24'd0, v}, 32'h65);
        check("R9 after read", {24'd0, lsr}, 32'h61);
        host_write(8'h00);

        // R4 odd parity wrong bit
        parity_mode = 3'b001;
        exp_q.push_back(8'h07);
        send_frame(8'h07, 1'b1, 1'b1, 1'b1); idle_bits(1);
        check("R4 odd bad", {24'd0, lsr}, 32'h65);
        host_read(v); host_write(8'h00);
        send_good(8'h07, 8'h07);
        check("R4 odd good", {24'd0, lsr}, 32'h61);
        host_write(8'h00);

        // R4 parity forced to 1 (101) and forced to 0 (111)
        parity_mode = 3'b101;
        exp_q.push_back(8'hC3);
        send_frame(8'hC3, 1'b0, 1'b1, 1'b1); idle_bits(1);
        check("R4 mark bad", {24'd0, lsr}, 32'h65);
        host_read(v); host_write(8'h00);
        send_good(8'hC3, 8'hC3);
        check("R4 mark good", {24'd0, lsr}, 32'h61);
        host_write(8'h00);
        parity_mode = 3'b111;
        exp_q.push_back(8'h3C);
        send_frame(8'h3C, 1'b1, 1'b1, 1'b1); idle_bits(1);
        check("R4 space bad", {24'd0, lsr}, 32'h65);
        host_read(v); host_write(8'h00);
        send_good(8'h3C, 8'h3C);
        check("R4 space good", {24'd0, lsr}, 32'h61);
        host_write(8'h00);
        parity_mode = 3'b000;

        // R5 low stop with nonzero data: framing only
        exp_q.push_back(8'h81);
        send_frame(8'h81, 1'b0, 1'b0, 1'b1); idle_bits(1);
        check("R5 framing", {24'd0, lsr}, 32'h69);
        host_read(v); host_write(8'h00);
        check("R5 cleared", {24'd0, lsr}, 32'h60);

        // R6 + R13 break held low for many bit times, even parity enabled
        parity_mode = 3'b011;
        exp_q.push_back(8'h00);
        rxd = 1'b0;
        repeat (40 * BIT_CLKS) @(negedge clk);
        idle_bits(2);
        check("R6 break flags", {24'd0, lsr}, 32'h79);
        check("R13 single char on long low", {31'd0, exp_q.size() == 0}, 32'd1);
        host_read(v); host_write(8'h00);
        parity_mode = 3'b000;

        // R8 overrun keeps the first character
        send_good(8'h11, 8'h11);
        send_frame(8'h22, 1'b0, 1'b1, 1'b1); idle_bits(1);
        check("R8 overrun flag", {24'd0, lsr}, 32'h63);
        check("R8 old data kept", {24'd0, rx_data}, 32'h11);
        host_read(v);
        check("R8 read keeps ready", {24'd0, lsr}, 32'h61);
        host_write(8'h00);

        // R2 glitch shorter than half a bit is dropped
        rxd = 1'b0;
        repeat (6 * TICK_DIV) @(negedge clk);
        idle_bits(12);
        check("R2 glitch dropped", {24'd0, lsr}, 32'h60);
        send_good(8'h5C, 8'h5C);
        check("R2 next char ok", {24'd0, lsr}, 32'h61);
        host_write(8'h00);

        // R12 two stop bits: good, then second stop low
        two_stop = 1'b1;
        send_good(8'h96, 8'h96);
        check("R12 two stops good", {24'd0, lsr}, 32'h61);
        host_write(8'h00);
        exp_q.push_back(8'h69);
        send_frame(8'h69, 1'b0, 1'b1, 1'b0); idle_bits(1);
        check("R12 late stop framing", {24'd0, lsr}, 32'h69);
        check("R12 data delivered", {24'd0, rx_data}, 32'h69);
        host_read(v); host_write(8'h00);
        two_stop = 1'b0;

        // R11 transmitter status bits
        tx_empty = 1'b0;
        @(negedge clk);
        check("R11 tx empty low", {24'd0, lsr}, 32'h40);
        tx_idle = 1'b0;
        @(negedge clk);
        check("R11 tx idle low", {24'd0, lsr}, 32'h00);
        tx_idle = 1'b1; tx_empty = 1'b1;
        @(negedge clk);
        check("R11 restored", {24'd0, lsr}, 32'h60);

        check("R7 scoreboard drained", exp_q.size(), 32'd0);
        finished = 1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule